// File: doc/BRIEF.md
# Capture/Compare Timer Channel

This block is one 16-bit counting channel with two general registers. Each register works on its own as either an output comparator or an input capture latch. The counter advances on a tick drawn from one of eight sources: the system clock divided by 1, 2, 4 or 8, or the rising edge of one of four external clock pins. A compare match drives its own waveform pin low, high or toggles it. A capture stores the running count when its input pin shows the chosen edge.

The counter can be zeroed by an event on either register or by a clear shared with other channels. It can also be loaded from a shared preset value, so several channels stay in step. A PWM mode uses register 0 for the duty point and register 1 for the period. Three sticky flags (register 0 event, register 1 event, overflow) each drive an interrupt line through their own enable. All settings are written through a small address/data write port.

Top module: `cc_timer_chan`

## Requirements
- R1: After reset the count is 0, both general registers are 0xFFFF, all flags, interrupts and waveform pins are 0, and the counter is stopped.
- R2: Write address 0 holds source select in bits [2:0], clear source in [4:3], PWM enable in [5] and run in [6]. Source values 0 to 3 advance the count once every 1, 2, 4 or 8 cycles while run is 1. The divider restarts from zero while run is 0, so N running cycles give floor(N/divisor) steps.
- R3: Source values 4 to 7 select external pin 0 to 3. Each pin passes through two synchronizing flops, and the count steps once per rising edge of the selected pin only. Edges on the other pins have no effect.
- R4: Addresses 1 and 2 configure register 0 and 1: bit [0] capture (1) or compare (0), [2:1] match action (0 none, 1 low, 2 high, 3 toggle), [4:3] capture edge, [5] initial level. In compare mode a step taken while the count equals the register applies the action to that register's waveform pin and sets its flag.
- R5: In capture mode the register latches the current count on the selected edge of its synchronized pin (edge field 0 rising, 1 falling, 2 or 3 both) and sets its flag. Edges not selected are ignored.
- R6: Clear source 1 or 2 zeroes the count on an event of register 0 or 1, in place of the step. sync_clr_o is high in that cycle. Clear source 3 zeroes the count when sync_clr_i is high, and sync_clr_i is ignored under other clear sources.
- R7: A step from 0xFFFF to 0x0000 sets flag bit 2.
- R8: Address 3 holds interrupt enables and writing 1s to address 4 clears the matching flags. Flag bit 0 is register 0, bit 1 is register 1 and bit 2 is overflow. A new event wins over a clear in the same cycle. Each irq_o bit is its flag ANDed with its enable.
- R9: Writing a register's configuration loads its initial level bit onto its waveform pin at once.
- R10: In PWM mode both registers compare, and the counter clears on a register 1 match. Waveform pin 0 goes high on a register 1 match and low on a register 0 match, so it is high for (reg0+1) of every (reg1+1) steps.
- R11: A high sync_pre_i loads sync_val_i into the count.
- R12: Priority on the count is: write to address 5 first, then sync preset, then clear, then step. Addresses 6 and 7 write the general registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| ext_clk_i | input | 4 | External count clock pins |
| cap_i | input | 2 | Capture pins for register 0 and 1 |
| sync_pre_i | input | 1 | Shared preset strobe |
| sync_val_i | input | 16 | Shared preset value |
| sync_clr_i | input | 1 | Shared clear from other channels |
| wave_o | output | 2 | Waveform pins for register 0 and 1 |
| cnt_o | output | 16 | Current count |
| gr0_o | output | 16 | General register 0 |
| gr1_o | output | 16 | General register 1 |
| flags_o | output | 3 | Sticky event flags |
| irq_o | output | 3 | Enabled interrupt requests |
| sync_clr_o | output | 1 | This channel clears its own count this cycle |

## Verification
A write to the count and a counting step can land on the same clock edge. So can a shared preset and a write, and a register event and a flag clear. The bench lets the counter run at full rate and writes a new count in the middle of the run. It expects to see exactly the written value after that edge, and the value plus one on the following edge. It applies the preset and a write in the same cycle and expects the written value. Assertions check that every step, clear, preset and write lands in the cycle after its cause.

// File: rtl/cct_pkg.sv
package cct_pkg;

  typedef enum logic [1:0] {ACT_NONE, ACT_LOW, ACT_HIGH, ACT_TOG} act_e;
  typedef enum logic [1:0] {EDG_RISE, EDG_FALL, EDG_BOTH, EDG_ANY} edg_e;
  typedef enum logic [1:0] {CLR_NONE, CLR_GR0, CLR_GR1, CLR_SYNC} clr_e;

  typedef struct packed {
    logic lvl;
    edg_e edg;
    act_e act;
    logic cap;
  } io_cfg_t;

  typedef struct packed {
    logic       run;
    logic       pwm;
    clr_e       clr;
    logic [2:0] src;
  } ctl_t;

  localparam logic [2:0] ADR_CTL  = 3'd0;
  localparam logic [2:0] ADR_IO0  = 3'd1;
  localparam logic [2:0] ADR_IO1  = 3'd2;
  localparam logic [2:0] ADR_IE   = 3'd3;
  localparam logic [2:0] ADR_FCLR = 3'd4;
  localparam logic [2:0] ADR_CNT  = 3'd5;
  localparam logic [2:0] ADR_GR0  = 3'd6;
  localparam logic [2:0] ADR_GR1  = 3'd7;

  function automatic logic apply_act(input act_e a, input logic cur);
    case (a)
      ACT_LOW:  return 1'b0;
      ACT_HIGH: return 1'b1;
      ACT_TOG:  return ~cur;
      default:  return cur;
    endcase
  endfunction

  function automatic logic edge_hit(input edg_e e, input logic rise, input logic fall);
    case (e)
      EDG_RISE: return rise;
      EDG_FALL: return fall;
      default:  return rise | fall;
    endcase
  endfunction

  function automatic logic div_tick(input logic [1:0] k, input logic [2:0] p);
    case (k)
      2'd0:    return 1'b1;
      2'd1:    return p[0];
      2'd2:    return &p[1:0];
      default: return &p;
    endcase
  endfunction

endpackage

// File: rtl/cct_tick_sel.sv
module cct_tick_sel #(
  parameter int N_EXT = 4,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [2:0]       src,
  input  logic [N_EXT-1:0] ext_i,
  output logic             tick
);
  import cct_pkg::*;

  localparam int PRE_W = 3;

  logic [SYNC:0][N_EXT-1:0] sh;
  logic [N_EXT-1:0]         ext_rise;
  logic [PRE_W-1:0]         presc;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC-1:0], ext_i};
  end

  assign ext_rise = sh[SYNC-1] & ~sh[SYNC];

  always_ff @(posedge clk) begin
    if (!rst_n || !run) presc <= '0;
    else                presc <= presc + 1'b1;
  end

  always_comb begin
    if (src[2]) tick = run & ext_rise[src[1:0]];
    else        tick = run & div_tick(src[1:0], presc);
  end

endmodule

// File: rtl/cct_cap_edge.sv
module cct_cap_edge #(
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_i,
  input  cct_pkg::edg_e sel,
  output logic          hit
);
  import cct_pkg::*;

  logic [SYNC:0] sh;
  logic          rise, fall;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC-1:0], pin_i};
  end

  assign rise = sh[SYNC-1] & ~sh[SYNC];
  assign fall = ~sh[SYNC-1] & sh[SYNC];
  assign hit  = edge_hit(sel, rise, fall);

endmodule

// File: rtl/cct_wave_out.sv
module cct_wave_out (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          lvl,
  input  logic          pwm_set,
  input  logic          pwm_clr,
  input  logic          hit,
  input  cct_pkg::act_e act,
  output logic          wave_o
);
  import cct_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n)       wave_o <= 1'b0;
    else if (load)    wave_o <= lvl;
    else if (pwm_set) wave_o <= 1'b1;
    else if (pwm_clr) wave_o <= 1'b0;
    else if (hit)     wave_o <= apply_act(act, wave_o);
  end

endmodule

// File: rtl/cc_timer_chan.sv
module cc_timer_chan #(
  parameter int CNT_W       = 16,
  parameter int N_EXT       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [N_EXT-1:0] ext_clk_i,
  input  logic [1:0]       cap_i,
  input  logic             sync_pre_i,
  input  logic [CNT_W-1:0] sync_val_i,
  input  logic             sync_clr_i,
  output logic [1:0]       wave_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] gr0_o,
  output logic [CNT_W-1:0] gr1_o,
  output logic [2:0]       flags_o,
  output logic [2:0]       irq_o,
  output logic             sync_clr_o
);
  import cct_pkg::*;

  localparam int NGR = 2;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  ctl_t             ctl;
  io_cfg_t          cfg [NGR];
  logic [2:0]       ie;
  logic [2:0]       flags;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] gr [NGR];

  // named events, visible to the checker
  logic             tick;
  logic             ctl_wr, ie_wr, fclr_wr, cnt_wr;
  logic [NGR-1:0]   cfg_wr, gr_wr;
  logic [NGR-1:0]   is_cap, cap_hit, match_evt, cap_evt, gr_evt;
  logic             own_clr, clr_evt, ovf_evt;

  function automatic logic [CNT_W-1:0] next_count(
    input logic             wr,  input logic [CNT_W-1:0] wv,
    input logic             pre, input logic [CNT_W-1:0] pv,
    input logic             clr, input logic             tk,
    input logic [CNT_W-1:0] cur);
    if (wr)       return wv;
    else if (pre) return pv;
    else if (clr) return '0;
    else if (tk)  return cur + 1'b1;
    else          return cur;
  endfunction

  function automatic logic [2:0] next_flags(
    input logic [2:0] cur, input logic [2:0] clr_mask, input logic [2:0] set);
    return (cur & ~clr_mask) | set;
  endfunction

  // write decode
  assign ctl_wr    = wr_en && (wr_addr == ADR_CTL);
  assign ie_wr     = wr_en && (wr_addr == ADR_IE);
  assign fclr_wr   = wr_en && (wr_addr == ADR_FCLR);
  assign cnt_wr    = wr_en && (wr_addr == ADR_CNT);
  assign cfg_wr[0] = wr_en && (wr_addr == ADR_IO0);
  assign cfg_wr[1] = wr_en && (wr_addr == ADR_IO1);
  assign gr_wr[0]  = wr_en && (wr_addr == ADR_GR0);
  assign gr_wr[1]  = wr_en && (wr_addr == ADR_GR1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0;
      ie  <= '0;
    end else begin
      if (ctl_wr) ctl <= ctl_t'(wr_data[6:0]);
      if (ie_wr)  ie  <= wr_data[2:0];
    end
  end

  cct_tick_sel #(.N_EXT(N_EXT), .SYNC(SYNC_STAGES)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(ctl.run), .src(ctl.src),
    .ext_i(ext_clk_i), .tick(tick)
  );

  for (genvar g = 0; g < NGR; g++) begin : g_gr
    always_ff @(posedge clk) begin
      if (!rst_n)         cfg[g] <= '0;
      else if (cfg_wr[g]) cfg[g] <= io_cfg_t'(wr_data[5:0]);
    end

    cct_cap_edge #(.SYNC(SYNC_STAGES)) u_cap (
      .clk(clk), .rst_n(rst_n), .pin_i(cap_i[g]), .sel(cfg[g].edg), .hit(cap_hit[g])
    );

    assign is_cap[g]    = cfg[g].cap & ~ctl.pwm;
    assign match_evt[g] = tick & ~is_cap[g] & (cnt == gr[g]);
    assign cap_evt[g]   = is_cap[g] & cap_hit[g];
    assign gr_evt[g]    = match_evt[g] | cap_evt[g];

    always_ff @(posedge clk) begin
      if (!rst_n)          gr[g] <= CNT_MAX;
      else if (gr_wr[g])   gr[g] <= wr_data;
      else if (cap_evt[g]) gr[g] <= cnt;
    end

    cct_wave_out u_wave (
      .clk(clk), .rst_n(rst_n),
      .load(cfg_wr[g]), .lvl(wr_data[5]),
      .pwm_set((g == 0) ? (ctl.pwm & match_evt[1]) : 1'b0),
      .pwm_clr((g == 0) ? (ctl.pwm & match_evt[0]) : 1'b0),
      .hit(match_evt[g] & ~ctl.pwm),
      .act(cfg[g].act),
      .wave_o(wave_o[g])
    );
  end

  always_comb begin
    if (ctl.pwm) own_clr = match_evt[1];
    else         own_clr = ((ctl.clr == CLR_GR0) & gr_evt[0]) |
                           ((ctl.clr == CLR_GR1) & gr_evt[1]);
  end

  assign clr_evt = own_clr | (~ctl.pwm & (ctl.clr == CLR_SYNC) & sync_clr_i);
  assign ovf_evt = tick & (cnt == CNT_MAX) & ~cnt_wr & ~sync_pre_i & ~clr_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      flags <= '0;
    end else begin
      cnt   <= next_count(cnt_wr, wr_data, sync_pre_i, sync_val_i, clr_evt, tick, cnt);
      flags <= next_flags(flags, fclr_wr ? wr_data[2:0] : 3'b000,
                          {ovf_evt, gr_evt[1], gr_evt[0]});
    end
  end

  assign cnt_o      = cnt;
  assign gr0_o      = gr[0];
  assign gr1_o      = gr[1];
  assign flags_o    = flags;
  assign irq_o      = flags & ie;
  assign sync_clr_o = own_clr;

endmodule

// File: rtl/cct_checker.sv
module cct_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             cnt_wr,
  input logic             sync_pre,
  input logic [CNT_W-1:0] sync_val,
  input logic             clr_evt,
  input logic             ovf_evt,
  input logic [1:0]       match_evt,
  input logic [1:0]       cap_evt,
  input logic [1:0]       gr_wr,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] cnt_o,
  input logic [CNT_W-1:0] gr0_o,
  input logic [CNT_W-1:0] gr1_o,
  input logic [2:0]       flags_o
);

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && !sync_pre && !clr_evt) |=> (cnt_o == CNT_W'($past(cnt_o) + 1'b1)));

  assert_match0_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt[0] |=> flags_o[0]);

  assert_match1_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt[1] |=> flags_o[1]);

  assert_cap0_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt[0] && !gr_wr[0]) |=> (gr0_o == $past(cnt_o)));

  assert_cap1_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt[1] && !gr_wr[1]) |=> (gr1_o == $past(cnt_o)));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !cnt_wr && !sync_pre) |=> (cnt_o == '0));

  assert_ovf_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flags_o[2]);

  assert_preset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_pre && !cnt_wr) |=> (cnt_o == $past(sync_val)));

  assert_wr_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_o == $past(wr_data)));

endmodule

bind cc_timer_chan cct_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr),
  .sync_pre(sync_pre_i), .sync_val(sync_val_i), .clr_evt(clr_evt),
  .ovf_evt(ovf_evt), .match_evt(match_evt), .cap_evt(cap_evt),
  .gr_wr(gr_wr), .wr_data(wr_data), .cnt_o(cnt_o), .gr0_o(gr0_o),
  .gr1_o(gr1_o), .flags_o(flags_o)
);

// File: tb/sim_cc_timer_chan.sv
`timescale 1ns/1ps
module sim_cc_timer_chan;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  ext_clk_i = '0;
  logic [1:0]  cap_i = '0;
  logic        sync_pre_i = 1'b0;
  logic [15:0] sync_val_i = '0;
  logic        sync_clr_i = 1'b0;
  logic [1:0]  wave_o;
  logic [15:0] cnt_o, gr0_o, gr1_o;
  logic [2:0]  flags_o, irq_o;
  logic        sync_clr_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cc_timer_chan u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_clk_i(ext_clk_i), .cap_i(cap_i), .sync_pre_i(sync_pre_i),
    .sync_val_i(sync_val_i), .sync_clr_i(sync_clr_i), .wave_o(wave_o),
    .cnt_o(cnt_o), .gr0_o(gr0_o), .gr1_o(gr1_o), .flags_o(flags_o),
    .irq_o(irq_o), .sync_clr_o(sync_clr_o)
  );

  typedef struct packed {
    logic [2:0]  src;
    logic [15:0] start;
    logic [7:0]  n;
    logic [15:0] exp_cnt;
    logic        exp_ovf;
  } vec_t;

  // R2 / R7 counting vectors: source, start, running cycles, expected count, overflow
  localparam vec_t VECS [6] = '{
    '{3'd0, 16'h0000, 8'd10, 16'h000A, 1'b0},
    '{3'd1, 16'h0010, 8'd10, 16'h0015, 1'b0},
    '{3'd2, 16'h0100, 8'd13, 16'h0103, 1'b0},
    '{3'd3, 16'h1000, 8'd20, 16'h1002, 1'b0},
    '{3'd0, 16'hFFFE, 8'd3,  16'h0001, 1'b1},
    '{3'd3, 16'h00FF, 8'd8,  16'h0100, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 cnt", cnt_o, 16'h0000);
    check("R1 gr0", gr0_o, 16'hFFFF);
    check("R1 gr1", gr1_o, 16'hFFFF);
    check("R1 flags", flags_o, 3'b000);
    check("R1 irq", irq_o, 3'b000);
    check("R1 wave", wave_o, 2'b00);

    // R2 / R7 table walk
    foreach (VECS[i]) begin
      wr(3'd0, {9'd0, 7'(VECS[i].src)});
      wr(3'd4, 16'h0007);
      wr(3'd5, VECS[i].start);
      wr(3'd0, {9'd0, 1'b1, 3'b000, VECS[i].src});
      idle(int'(VECS[i].n));
      check($sformatf("R2 vec%0d cnt", i), cnt_o, VECS[i].exp_cnt);
      if (VECS[i].exp_ovf) check("R7 ovf flag", flags_o[2], 1'b1);
      wr(3'd0, 16'h0000);
    end
    wr(3'd4, 16'h0007);

    // R9 initial level
    wr(3'd1, 16'h0020);
    check("R9 level high", wave_o[0], 1'b1);
    wr(3'd1, 16'h0000);
    check("R9 level low", wave_o[0], 1'b0);

    // R4 / R6 compare toggle with clear on register 0
    wr(3'd0, 16'h0008);
    wr(3'd6, 16'd5);
    wr(3'd1, 16'h0006);
    wr(3'd5, 16'd0);
    wr(3'd0, 16'h0048);
    idle(5);
    check("R6 cnt at match", cnt_o, 16'd5);
    check("R6 sync_clr_o", sync_clr_o, 1'b1);
    idle(1);
    check("R6 cleared", cnt_o, 16'd0);
    check("R4 toggle 1", wave_o[0], 1'b1);
    check("R4 flag0", flags_o[0], 1'b1);
    idle(6);
    check("R4 toggle 2", wave_o[0], 1'b0);
    // R4 drive high
    wr(3'd0, 16'h0008);
    wr(3'd5, 16'd0);
    wr(3'd1, 16'h0004);
    wr(3'd0, 16'h0048);
    idle(6);
    check("R4 high 1", wave_o[0], 1'b1);
    idle(6);
    check("R4 high 2", wave_o[0], 1'b1);
    wr(3'd0, 16'h0000);

    // R8 enables and write-1-to-clear
    check("R8 irq masked", irq_o[0], 1'b0);
    wr(3'd3, 16'h0001);
    check("R8 irq enabled", irq_o[0], 1'b1);
    wr(3'd4, 16'h0001);
    check("R8 flag cleared", flags_o[0], 1'b0);
    check("R8 irq dropped", irq_o[0], 1'b0);
    wr(3'd3, 16'h0000);

    // R12 write beats a step in the same cycle
    wr(3'd0, 16'h0040);
    idle(3);
    wr(3'd5, 16'h0100);
    check("R12 write wins", cnt_o, 16'h0100);
    idle(1);
    check("R12 step after write", cnt_o, 16'h0101);
    wr(3'd0, 16'h0000);

    // R5 capture edges on register 1
    wr(3'd2, 16'h0001);
    wr(3'd7, 16'h0000);
    wr(3'd5, 16'h1234);
    cap_i[1] = 1'b1; idle(4);
    check("R5 rise capture", gr1_o, 16'h1234);
    check("R5 flag1", flags_o[1], 1'b1);
    wr(3'd5, 16'h2222);
    cap_i[1] = 1'b0; idle(4);
    check("R5 fall ignored", gr1_o, 16'h1234);
    wr(3'd2, 16'h0009);
    cap_i[1] = 1'b1; idle(4);
    check("R5 rise ignored", gr1_o, 16'h1234);
    wr(3'd5, 16'h3333);
    cap_i[1] = 1'b0; idle(4);
    check("R5 fall capture", gr1_o, 16'h3333);
    wr(3'd2, 16'h0011);
    wr(3'd5, 16'h4444);
    cap_i[1] = 1'b1; idle(4);
    check("R5 both capture", gr1_o, 16'h4444);

    // R6 clear on capture of register 1
    wr(3'd0, 16'h0010);
    wr(3'd5, 16'h0555);
    cap_i[1] = 1'b0; idle(4);
    check("R6 capture clear cnt", cnt_o, 16'h0000);
    check("R6 capture value", gr1_o, 16'h0555);

    // R6 shared clear
    wr(3'd0, 16'h0000);
    wr(3'd5, 16'h0077);
    @(negedge clk); sync_clr_i = 1'b1; @(negedge clk); sync_clr_i = 1'b0;
    check("R6 sync clear ignored", cnt_o, 16'h0077);
    wr(3'd0, 16'h0018);
    @(negedge clk); sync_clr_i = 1'b1; @(negedge clk); sync_clr_i = 1'b0;
    check("R6 sync clear", cnt_o, 16'h0000);
    wr(3'd0, 16'h0000);

    // R11 preset, and R12 write beats preset
    sync_val_i = 16'hABCD;
    @(negedge clk); sync_pre_i = 1'b1; @(negedge clk); sync_pre_i = 1'b0;
    check("R11 preset", cnt_o, 16'hABCD);
    @(negedge clk);
    sync_pre_i = 1'b1; wr_en = 1'b1; wr_addr = 3'd5; wr_data = 16'h0042;
    @(negedge clk);
    sync_pre_i = 1'b0; wr_en = 1'b0;
    check("R12 write beats preset", cnt_o, 16'h0042);

    // R3 external pin 0, pin 1 toggling as a distractor
    wr(3'd5, 16'h0000);
    wr(3'd0, 16'h0044);
    for (int k = 0; k < 5; k++) begin
      ext_clk_i[0] = 1'b1; if (k < 3) ext_clk_i[1] = 1'b1;
      idle(2);
      ext_clk_i = '0;
      idle(2);
    end
    idle(4);
    check("R3 ext edges", cnt_o, 16'd5);
    wr(3'd0, 16'h0000);

    // R10 PWM duty 3 of period 8
    wr(3'd6, 16'd2);
    wr(3'd7, 16'd7);
    wr(3'd2, 16'h0000);
    wr(3'd1, 16'h0020);
    wr(3'd5, 16'd0);
    wr(3'd0, 16'h0060);
    begin
      int high = 0;
      for (int k = 0; k < 16; k++) begin
        @(negedge clk);
        if (wave_o[0]) high++;
      end
      check("R10 pwm high cycles", high, 32'd6);
      check("R10 pwm cnt at period end", cnt_o, 16'd0);
    end
    wr(3'd0, 16'h0000);

    finish_run();
  end

endmodule